// File: doc/BRIEF.md
# Prioritized Interrupt Encoder with Acknowledge Responder

This block collects seven active-high interrupt request lines, one for each priority level from 1 to 7. A rising edge on a line latches that level as pending. The highest pending level is shown on a 3-bit priority code for the processor. Level 7 ranks highest and has no mask. A code of zero means nothing is pending.

When the processor runs its interrupt acknowledge bus cycle, the block recognises the cycle from the function code and the upper address lines. It reads the level being acknowledged from address bits 3 to 1. If that level is pending, the block answers in one of two ways, chosen per level by a configuration bit:

- **Vectored:** an 8-bit vector on the low data byte, with the transfer acknowledge.
- **Autovectored:** the autovector request. The processor then uses vector 0x18 plus the level.

The reply lasts while the address strobe stays asserted. When the strobe ends, the pending latch for that level is cleared.

Top module: `irq_prio_responder`

## Requirements
- R1: `ipl` carries the highest pending level as a binary code (bit 0 least significant, 7 highest, 0 when nothing is pending). It follows the pending set in the cycle after the set changes.
- R2: A rising edge on `irq_req[i]` makes level i+1 pending. The level stays pending, and stays visible on `ipl`, until it is acknowledged, even if its request line falls.
- R3: An acknowledge cycle is recognised only when all of these hold:
  - `fc` equals 3'b111;
  - `addr[19:16]` are all ones;
  - every other address bit above bit 3 is one;
  - `addr_strobe` and `lo_strobe` are both high.
  Any other pattern gets no reply.
- R4: For a pending level L with `auto_sel[L-1]`=0, the block replies from the first clock edge after the acknowledge is recognised. The reply is `dtack`=1, `data_oe`=1 and `data_out` = `vec_tbl[(L-1)*8 +: 8]`.
- R5: For a pending level L with `auto_sel[L-1]`=1, the reply is `vpa`=1, with `dtack`=0 and `data_oe`=0.
- R6: `dtack` and `vpa` are never high together.
- R7: `dtack`, `vpa` and `data_oe` fall in the same cycle that `addr_strobe` falls, without waiting for a clock edge.
- R8: At the first clock edge with `addr_strobe` low after a reply, the acknowledged level stops being pending. The next lower pending level then appears on `ipl`.
- R9: If `addr[3:1]` names level 0, or a level that is not pending, the block gives no reply and clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 7 | Request lines; bit i is level i+1 |
| auto_sel | input | 7 | Per-level reply kind; bit i = 1 selects autovector for level i+1 |
| vec_tbl | input | 56 | Per-level vectors; byte i belongs to level i+1 |
| fc | input | 3 | Processor function code |
| addr | input | 23 | Address bits 23..1 |
| addr_strobe | input | 1 | Address strobe, active high |
| lo_strobe | input | 1 | Lower data strobe, active high |
| ipl | output | 3 | Encoded highest pending level |
| dtack | output | 1 | Transfer acknowledge for vectored replies |
| vpa | output | 1 | Autovector request |
| data_out | output | 8 | Vector for the low data byte |
| data_oe | output | 1 | Drive enable for `data_out` |

## Verification
The assertions check on every cycle that:
- the two reply signals are mutually exclusive;
- a reply exists only under an asserted strobe and a valid acknowledge decode;
- a vector or autovector reply matches the configuration of the level on the address lines;
- `ipl` can only drop right after an acknowledge.

Only the bench scenarios can show the rest:
- the priority order among many simultaneous requests;
- the request latch holding after its line falls;
- the silent cases for near-miss decode patterns and unpending levels;
- the exact edge at which the serviced level is retired and a lower one surfaces.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   localparam int LVL_W   = 3;
   localparam int NUM_LVL = (1 << LVL_W) - 1;
   localparam logic [2:0] FC_IACK = 3'b111;

   // highest set bit index + 1, zero when empty
   function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] p);
      logic [LVL_W-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_LVL; i++)
         if (p[i]) r = LVL_W'(i + 1);
      return r;
   endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
   import irq_ack_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] req,
   input  logic               clr_en,
   input  logic [LVL_W-1:0]   clr_lvl,
   output logic [NUM_LVL-1:0] pend
);
   logic [NUM_LVL-1:0] req_q;
   logic [NUM_LVL-1:0] clr_mask;

   always_comb begin
      clr_mask = '0;
      if (clr_en && clr_lvl != '0)
         clr_mask[int'(clr_lvl) - 1] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         pend  <= '0;
      end else begin
         req_q <= req;
         // a new edge wins over a clear of the same level
         pend  <= (pend & ~clr_mask) | (req & ~req_q);
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import irq_ack_pkg::*;
#(
   parameter bit IPL_REG = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] pend,
   output logic [LVL_W-1:0]   ipl
);
   logic [LVL_W-1:0] lvl_c;
   assign lvl_c = top_level(pend);

   generate
      if (IPL_REG) begin : g_reg
         logic [LVL_W-1:0] lvl_q;
         always_ff @(posedge clk) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= lvl_c;
         end
         assign ipl = lvl_q;
      end else begin : g_comb
         assign ipl = lvl_c;
      end
   endgenerate
endmodule

// File: rtl/iack_decode.sv
module iack_decode
   import irq_ack_pkg::*;
#(
   parameter int ADDR_HI = 23
)(
   input  logic [2:0]       fc,
   input  logic [ADDR_HI:1] addr,
   input  logic             addr_strobe,
   input  logic             lo_strobe,
   output logic             hit,
   output logic [LVL_W-1:0] lvl
);
   assign hit = addr_strobe && lo_strobe && (fc == FC_IACK) && (&addr[ADDR_HI:4]);
   assign lvl = addr[3:1];
endmodule

// File: rtl/iack_reply.sv
module iack_reply
   import irq_ack_pkg::*;
#(
   parameter int VEC_W = 8
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hit,
   input  logic [LVL_W-1:0]         lvl,
   input  logic [NUM_LVL-1:0]       pend,
   input  logic                     addr_strobe,
   input  logic [NUM_LVL-1:0]       auto_sel,
   input  logic [NUM_LVL*VEC_W-1:0] vec_tbl,
   output logic                     dtack,
   output logic                     vpa,
   output logic [VEC_W-1:0]         data_out,
   output logic                     data_oe,
   output logic                     active,
   output logic                     clr_en,
   output logic [LVL_W-1:0]         clr_lvl
);
   logic [LVL_W-1:0] lvl_q;
   logic             match;
   logic             is_auto;
   logic             live;
   int               sel;

   assign match = hit && (lvl != '0) && pend[int'(lvl) - 1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         lvl_q  <= '0;
      end else if (active) begin
         if (!addr_strobe) active <= 1'b0;
      end else if (match) begin
         active <= 1'b1;
         lvl_q  <= lvl;
      end
   end

   assign sel      = (lvl_q == '0) ? 0 : int'(lvl_q) - 1;
   assign is_auto  = auto_sel[sel];
   assign live     = active && addr_strobe;
   assign dtack    = live && !is_auto;
   assign vpa      = live && is_auto;
   assign data_oe  = dtack;
   assign data_out = dtack ? vec_tbl[sel*VEC_W +: VEC_W] : '0;
   assign clr_en   = active && !addr_strobe;
   assign clr_lvl  = lvl_q;
endmodule

// File: rtl/irq_prio_responder.sv
module irq_prio_responder
   import irq_ack_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int ADDR_HI = 23,
   parameter bit IPL_REG = 1'b0
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_LVL-1:0]       irq_req,
   input  logic [NUM_LVL-1:0]       auto_sel,
   input  logic [NUM_LVL*VEC_W-1:0] vec_tbl,
   input  logic [2:0]               fc,
   input  logic [ADDR_HI:1]         addr,
   input  logic                     addr_strobe,
   input  logic                     lo_strobe,
   output logic [LVL_W-1:0]         ipl,
   output logic                     dtack,
   output logic                     vpa,
   output logic [VEC_W-1:0]         data_out,
   output logic                     data_oe
);
   generate
      if (ADDR_HI < 19) begin : g_bad_addr
         $error("ADDR_HI must reach bit 19 for the acknowledge decode");
      end
      if (VEC_W < 1) begin : g_bad_vec
         $error("VEC_W must be positive");
      end
   endgenerate

   logic [NUM_LVL-1:0] pend;
   logic               hit;
   logic [LVL_W-1:0]   ack_lvl;
   logic               reply_act;
   logic               clr_en;
   logic [LVL_W-1:0]   clr_lvl;

   irq_req_latch u_latch (
      .clk(clk), .rst_n(rst_n), .req(irq_req),
      .clr_en(clr_en), .clr_lvl(clr_lvl), .pend(pend)
   );

   irq_prio_enc #(.IPL_REG(IPL_REG)) u_enc (
      .clk(clk), .rst_n(rst_n), .pend(pend), .ipl(ipl)
   );

   iack_decode #(.ADDR_HI(ADDR_HI)) u_dec (
      .fc(fc), .addr(addr), .addr_strobe(addr_strobe),
      .lo_strobe(lo_strobe), .hit(hit), .lvl(ack_lvl)
   );

   iack_reply #(.VEC_W(VEC_W)) u_reply (
      .clk(clk), .rst_n(rst_n), .hit(hit), .lvl(ack_lvl), .pend(pend),
      .addr_strobe(addr_strobe), .auto_sel(auto_sel), .vec_tbl(vec_tbl),
      .dtack(dtack), .vpa(vpa), .data_out(data_out), .data_oe(data_oe),
      .active(reply_act), .clr_en(clr_en), .clr_lvl(clr_lvl)
   );
endmodule

// File: rtl/irq_prio_responder_chk.sv
module irq_prio_responder_chk
   import irq_ack_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int ADDR_HI = 23
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_LVL-1:0]       auto_sel,
   input logic [NUM_LVL*VEC_W-1:0] vec_tbl,
   input logic [2:0]               fc,
   input logic [ADDR_HI:1]         addr,
   input logic                     addr_strobe,
   input logic [LVL_W-1:0]         ipl,
   input logic                     dtack,
   input logic                     vpa,
   input logic [VEC_W-1:0]         data_out,
   input logic                     reply_act
);
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(dtack && vpa));

   p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack || vpa) |-> addr_strobe);

   p_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack || vpa) |-> (fc == FC_IACK && (&addr[19:16]) && (&addr[ADDR_HI:4])));

   p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack && addr[3:1] != '0) |->
         (!auto_sel[int'(addr[3:1]) - 1] &&
          data_out == vec_tbl[(int'(addr[3:1]) - 1)*VEC_W +: VEC_W]));

   p_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vpa |-> (addr[3:1] != '0 && auto_sel[int'(addr[3:1]) - 1]));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl < $past(ipl)) |-> $past(reply_act));

   p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dtack || vpa) |-> addr[3:1] != '0);
endmodule

bind irq_prio_responder irq_prio_responder_chk #(.VEC_W(VEC_W), .ADDR_HI(ADDR_HI)) u_chk (
   .clk(clk), .rst_n(rst_n), .auto_sel(auto_sel), .vec_tbl(vec_tbl),
   .fc(fc), .addr(addr), .addr_strobe(addr_strobe), .ipl(ipl),
   .dtack(dtack), .vpa(vpa), .data_out(data_out), .reply_act(reply_act)
);

// File: tb/irq_prio_responder_bench.sv
module irq_prio_responder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  irq_req = '0;
   logic [6:0]  auto_sel = '0;
   logic [55:0] vec_tbl = '0;
   logic [2:0]  fc = '0;
   logic [23:1] addr = '0;
   logic        addr_strobe = 1'b0;
   logic        lo_strobe = 1'b0;
   logic [2:0]  ipl;
   logic        dtack, vpa, data_oe;
   logic [7:0]  data_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [6:0] model = '0;

   always #10 clk = ~clk;

   irq_prio_responder u_irq_prio_responder (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .auto_sel(auto_sel),
      .vec_tbl(vec_tbl), .fc(fc), .addr(addr), .addr_strobe(addr_strobe),
      .lo_strobe(lo_strobe), .ipl(ipl), .dtack(dtack), .vpa(vpa),
      .data_out(data_out), .data_oe(data_oe)
   );

   function automatic logic [2:0] exp_ipl(input logic [6:0] p);
      logic [2:0] r = 3'd0;
      for (int i = 0; i < 7; i++) if (p[i]) r = 3'(i + 1);
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk); irq_req = m;
      @(negedge clk); irq_req = '0;
      model = model | m;
      #1 check("R1 ipl after request", 32'(ipl), 32'(exp_ipl(model)));
   endtask

   task automatic bus_cycle(input logic [2:0] f, input logic [23:1] a,
                            input logic ls, input logic expect_reply);
      logic [2:0] l = a[3:1];
      @(negedge clk);
      fc = f; addr = a; addr_strobe = 1'b1; lo_strobe = ls;
      @(posedge clk); #1;
      if (expect_reply) begin
         if (auto_sel[l-1]) begin
            check("R5 vpa", 32'(vpa), 1);
            check("R5 dtack low", 32'(dtack), 0);
            check("R5 data_oe low", 32'(data_oe), 0);
         end else begin
            check("R4 dtack", 32'(dtack), 1);
            check("R4 vpa low", 32'(vpa), 0);
            check("R4 data_oe", 32'(data_oe), 1);
            check("R4 vector", 32'(data_out), 32'(vec_tbl[(l-1)*8 +: 8]));
         end
         check("R2 ipl held during reply", 32'(ipl), 32'(exp_ipl(model)));
      end else begin
         check("R3/R9 silent", 32'({dtack, vpa, data_oe}), 0);
      end
      @(negedge clk); addr_strobe = 1'b0; lo_strobe = 1'b0;
      #1 check("R7 reply removed with strobe", 32'({dtack, vpa, data_oe}), 0);
      if (expect_reply) model[l-1] = 1'b0;
      @(posedge clk); #1;
      check("R8 ipl after acknowledge", 32'(ipl), 32'(exp_ipl(model)));
      @(negedge clk); fc = '0; addr = '0;
   endtask

   function automatic logic [23:1] iack_addr(input logic [2:0] l);
      return {20'hFFFFF, l};
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 check("R1 reset ipl", 32'(ipl), 0);
      check("R1 reset outputs", 32'({dtack, vpa, data_oe}), 0);
      @(negedge clk); rst_n = 1'b1;

      auto_sel = 7'b0100101;
      for (int i = 0; i < 7; i++) vec_tbl[i*8 +: 8] = 8'h40 + 8'(i);

      // R2: request line falls, level stays pending
      pulse(7'b0000100);
      repeat (4) @(posedge clk);
      #1 check("R2 held after line falls", 32'(ipl), 3);

      // R1: priority ordering, level 7 on top
      pulse(7'b1010010);
      check("R1 highest is 7", 32'(ipl), 7);

      // R3: near-miss decodes are silent
      bus_cycle(3'b110, iack_addr(3'd7), 1'b1, 1'b0);
      bus_cycle(3'b111, iack_addr(3'd7) & ~(23'd1 << 18), 1'b1, 1'b0);
      bus_cycle(3'b111, iack_addr(3'd7) & ~(23'd1 << 9), 1'b1, 1'b0);
      bus_cycle(3'b111, iack_addr(3'd7), 1'b0, 1'b0);
      check("R3 nothing cleared", 32'(ipl), 7);

      // R9: level 0 and an unpending level
      bus_cycle(3'b111, iack_addr(3'd0), 1'b1, 1'b0);
      bus_cycle(3'b111, iack_addr(3'd6), 1'b1, 1'b0);
      check("R9 nothing cleared", 32'(ipl), 7);

      // R4 vectored level 7, then R8 level 5 surfaces
      bus_cycle(3'b111, iack_addr(3'd7), 1'b1, 1'b1);
      check("R8 next level", 32'(ipl), 5);
      // R5 autovector level 3 acknowledged out of order
      bus_cycle(3'b111, iack_addr(3'd3), 1'b1, 1'b1);
      bus_cycle(3'b111, iack_addr(3'd5), 1'b1, 1'b1);
      bus_cycle(3'b111, iack_addr(3'd2), 1'b1, 1'b1);
      check("R8 all retired", 32'(ipl), 0);

      // random mix
      for (int n = 0; n < 80; n++) begin
         logic [2:0] l;
         auto_sel = 7'($urandom);
         for (int i = 0; i < 7; i++) vec_tbl[i*8 +: 8] = 8'($urandom);
         pulse(7'($urandom) & 7'($urandom));
         if (($urandom % 10) < 7 && model != '0) l = exp_ipl(model);
         else l = 3'($urandom % 8);
         bus_cycle(3'b111, iack_addr(l), 1'b1, (l != 0) && model[l-1]);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule